// File: doc/BRIEF.md
# Overlapped DMA Command-Bus Arbiter

This block decides which of several DMA masters may next use a shared command bus that feeds a single memory request interface. Each master raises its own request line. When the downstream interface reports that it can take a new request, the arbiter picks one requester in round-robin order and gives it a one-cycle grant pulse. It then selects that master's command word onto the shared bus for two beats: first the memory address, then the transfer type. After the second beat it releases the bus.

Arbitration for the following transfer runs while the current transfer moves its data. A new grant is held back until the downstream interface signals that the current transfer's data phase has started. Arbitration therefore overlaps data movement but never runs ahead of it. A master that withdraws its request before the grant decision is not chosen. The next requester in rotation order wins instead.

Top module: `dma_cmd_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mst_grant`, `cmd_sel` and `cmd_valid` are all zero and `cmd_bus` is zero.
- R2: A grant pulse appears only in the cycle after a clock edge at which `if_ready` was high.
- R3: `mst_grant` has at most one bit set, and each grant lasts exactly one cycle.
- R4: In the grant cycle, `cmd_sel` equals the grant and `cmd_beat` is 0 (address beat). In the next cycle `cmd_sel` is unchanged and `cmd_beat` is 1 (type beat). In the cycle after that, `cmd_sel` is zero. While `cmd_sel` has bit i set, `cmd_bus` equals master i's slice `mst_cmd[i*CMD_W +: CMD_W]`.
- R5: After a grant, no further grant is issued until `data_start` has been sampled high at an edge during or after that grant cycle. If `data_start` is sampled at the same edge as the arbitration decision, the decision made at that edge is still blocked. The grant can come one edge later.
- R6: The winner is the first master with its request high at the decision edge, searching upward from the index after the most recently granted master and wrapping around. After reset the search starts at master 0.
- R7: A master whose request is low at the decision edge is skipped, even if it was requesting earlier.
- R8: Whenever `cmd_valid` is low, `cmd_sel` and `cmd_bus` are zero. `cmd_valid` is high exactly when a master is selected.
- R9: On an idle, unblocked arbiter with `if_ready` high, a request sampled at edge k gives its grant and address beat in the cycle following edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_req | input | N_MST | Per-master request lines |
| mst_cmd | input | N_MST*CMD_W | Per-master command words, master i in slice i |
| if_ready | input | 1 | Downstream interface can accept a new request |
| data_start | input | 1 | Current transfer's data phase has begun |
| mst_grant | output | N_MST | One-cycle grant pulse per master |
| cmd_sel | output | N_MST | One-hot bus driver enable |
| cmd_valid | output | 1 | A command beat is on the bus |
| cmd_beat | output | 1 | 0 for the address beat, 1 for the type beat |
| cmd_bus | output | CMD_W | Shared command bus |

## Verification
The interesting collision is between the release of the data-phase block and a pending arbitration decision. `data_start` can arrive in the very cycle the arbiter would otherwise grant, while other masters are requesting and `if_ready` is high. The random stimulus provokes this often: `data_start` pulses at random, and every cycle `if_ready` and the request lines are redrawn. A directed case also forces it once. A cycle-level reference model in the bench judges each result and expects the grant exactly one edge after the decision that `data_start` unblocks. A second directed case withdraws the rotation favourite while the arbiter is blocked, and checks that the next requester in order wins.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    PH_ARB  = 2'd0,
    PH_ADDR = 2'd1,
    PH_TYPE = 2'd2
  } arb_phase_e;

  // one-hot vector of width n from an index
  function automatic logic [63:0] idx_to_onehot(input int unsigned idx);
    logic [63:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/dma_rr_pick.sv
module dma_rr_pick #(
  parameter int N_MST = 4,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] req,
  input  logic [IDX_W-1:0] last_idx,
  output logic             any_req,
  output logic [IDX_W-1:0] win_idx
);
  // search upward from the slot after last_idx, wrapping around
  always_comb begin
    logic found;
    int   pos;
    found   = 1'b0;
    win_idx = '0;
    for (int k = 1; k <= N_MST; k++) begin
      pos = (int'(last_idx) + k) % N_MST;
      if (!found && req[pos]) begin
        found   = 1'b1;
        win_idx = IDX_W'(pos);
      end
    end
    any_req = found;
  end
endmodule

// File: rtl/dma_cmd_mux.sv
module dma_cmd_mux #(
  parameter int N_MST = 4,
  parameter int CMD_W = 32
) (
  input  logic [N_MST-1:0]       sel,
  input  logic [N_MST*CMD_W-1:0] words,
  output logic [CMD_W-1:0]       bus
);
  logic [CMD_W-1:0] gated [N_MST];

  for (genvar i = 0; i < N_MST; i++) begin : g_gate
    assign gated[i] = sel[i] ? words[i*CMD_W +: CMD_W] : '0;
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < N_MST; i++) bus = bus | gated[i];
  end
endmodule

// File: rtl/dma_cmd_arbiter.sv
module dma_cmd_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_MST = 4,
  parameter int CMD_W = 32,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_MST-1:0]       mst_req,
  input  logic [N_MST*CMD_W-1:0] mst_cmd,
  input  logic                   if_ready,
  input  logic                   data_start,
  output logic [N_MST-1:0]       mst_grant,
  output logic [N_MST-1:0]       cmd_sel,
  output logic                   cmd_valid,
  output logic                   cmd_beat,
  output logic [CMD_W-1:0]       cmd_bus
);
  arb_phase_e       phase_q;
  logic             blocked_q;
  logic [IDX_W-1:0] last_q;
  logic [N_MST-1:0] grant_q, sel_q;

  // named internal events
  logic             any_req;
  logic [IDX_W-1:0] win_idx;
  logic             can_arb;
  logic             do_grant;
  logic [N_MST-1:0] win_oh;

  dma_rr_pick #(.N_MST(N_MST)) u_pick (
    .req      (mst_req),
    .last_idx (last_q),
    .any_req  (any_req),
    .win_idx  (win_idx)
  );

  assign can_arb  = (phase_q == PH_ARB) && !blocked_q && if_ready;
  assign do_grant = can_arb && any_req;
  assign win_oh   = N_MST'(idx_to_onehot(int'(win_idx)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_ARB;
      blocked_q <= 1'b0;
      last_q    <= IDX_W'(N_MST - 1);
      grant_q   <= '0;
      sel_q     <= '0;
    end else begin
      grant_q <= '0;
      if (do_grant) blocked_q <= 1'b1;
      else if (data_start) blocked_q <= 1'b0;
      unique case (phase_q)
        PH_ARB: if (do_grant) begin
          grant_q <= win_oh;
          sel_q   <= win_oh;
          last_q  <= win_idx;
          phase_q <= PH_ADDR;
        end
        PH_ADDR: phase_q <= PH_TYPE;
        PH_TYPE: begin
          phase_q <= PH_ARB;
          sel_q   <= '0;
        end
        default: phase_q <= PH_ARB;
      endcase
    end
  end

  dma_cmd_mux #(.N_MST(N_MST), .CMD_W(CMD_W)) u_mux (
    .sel   (sel_q),
    .words (mst_cmd),
    .bus   (cmd_bus)
  );

  assign mst_grant = grant_q;
  assign cmd_sel   = sel_q;
  assign cmd_valid = |sel_q;
  assign cmd_beat  = (phase_q == PH_TYPE);
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int N_MST = 4,
  parameter int CMD_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] mst_req,
  input logic             if_ready,
  input logic             data_start,
  input logic [N_MST-1:0] mst_grant,
  input logic [N_MST-1:0] cmd_sel,
  input logic             cmd_valid,
  input logic             cmd_beat,
  input logic [CMD_W-1:0] cmd_bus
);
  // tracks a granted transfer whose data phase has not yet been seen
  logic waiting;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) waiting <= 1'b0;
    else if (data_start) waiting <= 1'b0;
    else if (|mst_grant) waiting <= 1'b1;
  end

  a_r2_ready_seen: assert property (@(posedge clk) disable iff (!rst_n)
    |mst_grant |-> $past(if_ready));
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mst_grant));
  a_r3_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    |mst_grant |=> (mst_grant == '0));
  a_r4_addr_beat: assert property (@(posedge clk) disable iff (!rst_n)
    |mst_grant |-> (cmd_sel == mst_grant) && !cmd_beat);
  a_r4_type_beat: assert property (@(posedge clk) disable iff (!rst_n)
    |mst_grant |=> (cmd_sel == $past(mst_grant)) && cmd_beat);
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    |mst_grant |=> ##1 (cmd_sel == '0));
  a_r5_wait_data: assert property (@(posedge clk) disable iff (!rst_n)
    |mst_grant |-> !$past(waiting));
  a_r6_was_requesting: assert property (@(posedge clk) disable iff (!rst_n)
    |mst_grant |-> (($past(mst_req) & mst_grant) != '0));
  a_r8_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (cmd_bus == '0) && (cmd_sel == '0));
  a_r8_valid_sel: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $countones(cmd_sel) == 1);
endmodule

bind dma_cmd_arbiter dma_arb_chk #(.N_MST(N_MST), .CMD_W(CMD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mst_req    (mst_req),
  .if_ready   (if_ready),
  .data_start (data_start),
  .mst_grant  (mst_grant),
  .cmd_sel    (cmd_sel),
  .cmd_valid  (cmd_valid),
  .cmd_beat   (cmd_beat),
  .cmd_bus    (cmd_bus)
);

// File: tb/tb_dma_cmd_arbiter.sv
`timescale 1ns/1ps
module tb_dma_cmd_arbiter;
  localparam int N = 4;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   mst_req = '0;
  logic [N*W-1:0] mst_cmd = '0;
  logic           if_ready = 1'b0;
  logic           data_start = 1'b0;
  logic [N-1:0]   mst_grant, cmd_sel;
  logic           cmd_valid, cmd_beat;
  logic [W-1:0]   cmd_bus;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_cmd_arbiter #(.N_MST(N), .CMD_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .mst_cmd(mst_cmd),
    .if_ready(if_ready), .data_start(data_start), .mst_grant(mst_grant),
    .cmd_sel(cmd_sel), .cmd_valid(cmd_valid), .cmd_beat(cmd_beat),
    .cmd_bus(cmd_bus)
  );

  // reference model state, advanced on each rising edge
  int m_stage = 0;   // 0 arbitrate, 1 address, 2 type
  int m_last  = N - 1;
  int m_who   = -1;
  bit m_hold  = 0;
  logic [N-1:0] m_gnt = '0;

  function automatic int next_owner(input logic [N-1:0] r, input int prev);
    for (int s = 1; s <= N; s++)
      if (r[(prev + s) % N]) return (prev + s) % N;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_last = N - 1; m_who = -1; m_hold = 0; m_gnt = '0;
    end else begin
      int w;
      m_gnt = '0;
      w = next_owner(mst_req, m_last);
      if (m_stage == 0 && !m_hold && if_ready && w >= 0) begin
        m_gnt = '0; m_gnt[w] = 1'b1;
        m_who = w; m_last = w; m_stage = 1; m_hold = 1;
      end else begin
        if (data_start) m_hold = 0;
        if (m_stage == 1) m_stage = 2;
        else if (m_stage == 2) begin m_stage = 0; m_who = -1; end
      end
    end
  end

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [N-1:0] es;
    logic [W-1:0] eb;
    es = '0; eb = '0;
    if (m_who >= 0) begin es[m_who] = 1'b1; eb = mst_cmd[m_who*W +: W]; end
    check("R3/R6 grant", 64'(mst_grant), 64'(m_gnt));
    check("R4 select", 64'(cmd_sel), 64'(es));
    check("R8 valid", 64'(cmd_valid), 64'(m_who >= 0));
    check("R4 beat", 64'(cmd_beat), 64'(m_stage == 2));
    check("R4/R8 bus", 64'(cmd_bus), 64'(eb));
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    compare_all();
  endtask

  task automatic new_words();
    for (int i = 0; i < N; i++) mst_cmd[i*W +: W] = $urandom;
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    new_words();
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 grant", 64'(mst_grant), 0);
    check("R1 select", 64'(cmd_sel), 0);
    check("R1 valid", 64'(cmd_valid), 0);
    check("R1 bus", 64'(cmd_bus), 0);
    rst_n = 1'b1;
    step();
    check("R1 grant after release", 64'(mst_grant), 0);

    // R9: single request, idle, ready -> grant and address next cycle
    mst_req = 4'b0010; if_ready = 1'b1;
    step();
    check("R9 grant", 64'(mst_grant), 64'(4'b0010));
    check("R9 address beat", 64'(cmd_bus), 64'(mst_cmd[1*W +: W]));
    mst_req = 4'b0000;
    step(); step();
    // R7: blocked, favourite (2) withdraws, 3 must win after unblock
    mst_req = 4'b1100;
    step(); step();
    check("R5 held while blocked", 64'(mst_grant), 0);
    mst_req = 4'b1000;
    step();
    // R5: data_start in the same cycle as the would-be decision
    data_start = 1'b1;
    step();
    check("R5 no grant at unblocking edge", 64'(mst_grant), 0);
    data_start = 1'b0;
    step();
    check("R7 skip withdrawn master", 64'(mst_grant), 64'(4'b1000));
    mst_req = 4'b0000;
    step(); step();
    // R2: ready low blocks an otherwise legal grant
    data_start = 1'b1; step(); data_start = 1'b0;
    if_ready = 1'b0; mst_req = 4'b1111;
    step(); step();
    check("R2 no grant without ready", 64'(mst_grant), 0);
    // R6 rotation: all requesting, grant order should be 0,1,2,3
    if_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      check("R6 rotation", 64'(mst_grant), 64'(1 << k));
      step(); step();
      data_start = 1'b1; step(); data_start = 1'b0;
    end
    mst_req = '0; step(); step(); step();

    // random phase
    for (int c = 0; c < 4000; c++) begin
      mst_req    = N'($urandom) & N'($urandom | $urandom);
      if_ready   = ($urandom % 4) != 0;
      data_start = ($urandom % 10) < 3;
      if (($urandom % 8) == 0) new_words();
      step();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule